// File: doc/BRIEF.md
# Zero-Stuffing NRZI Serial Transmitter

This block sits on a serial transmit path. It takes one data bit per bit period. The bit arrives on `ser_din`, and a one-cycle strobe `bit_stb` marks when it is valid. The strobe is normally high for one system clock out of every four. When the data stream has carried a run of six ones, the block sends a zero bit of its own before it takes more data. This keeps the line from staying at one level for long stretches. The stuffed stream is then line coded so that every zero toggles the line and every one leaves it where it is.

Two versions of the stuffed stream come out: the plain level form (`nrz_out`) and the transition-coded line (`nrzi_out`). A third output, `stuff_flag`, is high for the bit period of each inserted zero. On the strobe that emits an inserted zero, the block does not take the bit that is waiting on `ser_din`. The source sees `stuff_flag` high after that strobe, so it keeps the same bit in place for the next strobe. A one-cycle `frame_start` pulse marks the start of a new frame of data and clears the run of ones. The idle line level is one. The framing sends a zero as its first bit, so the line shows a falling edge when a frame begins.

Top module: `zstuff_nrzi_tx`

## Requirements
- R1: After six data ones in a row are taken, the next strobe emits an inserted zero (`nrz_out`=0). A run of only five ones followed by a data zero inserts nothing.
- R2: `stuff_flag` is 1 for exactly the bit period of an inserted zero and 0 for data bits. The strobe that emits an inserted zero discards `ser_din`, whatever its value, and the held bit is taken on the next strobe.
- R3: The run count restarts after an inserted zero, so a fresh run of six data ones is needed before the next insertion.
- R4: `nrzi_out` toggles on every emitted zero, inserted zeros included, and keeps its level on every emitted one.
- R5: `frame_start` clears the run count. This holds both when the pulse is on a non-strobe cycle and when it coincides with a strobe. In the coincident case, that strobe's bit counts as the first bit of a new run.
- R6: On cycles where `bit_stb` is 0, changes on `ser_din` and `frame_start` leave all three outputs unchanged.
- R7: Reset is synchronous and active low. It sets `nrz_out`=1, `nrzi_out`=1, `stuff_flag`=0 and clears the run count.
- R8: Outputs are registered. They take their new value on the clock edge where `bit_stb` is sampled high and hold it for the rest of the bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_stb | input | 1 | Bit strobe; one system clock per bit period |
| ser_din | input | 1 | Serial data in, level coded, valid when `bit_stb` is high |
| frame_start | input | 1 | One-cycle pulse at the start of a frame; clears the run count |
| nrz_out | output | 1 | Stuffed stream, level coded |
| nrzi_out | output | 1 | Stuffed stream, transition coded (zero toggles the line) |
| stuff_flag | output | 1 | High for the bit period of an inserted zero |

## Verification
A run counter that is off by one shows up as an inserted zero one bit early or one bit late. This is visible on `nrz_out` and `stuff_flag` within a single bit period of the sixth one. A counter that is not cleared by a data zero, an inserted zero or `frame_start` inserts a zero where none is due. The stimulus therefore places five-one runs just before each of those clearing events. A stale line register puts `nrzi_out` at the wrong level. It then stays inverted from that bit onward, so every later check of the line level catches it.

// File: rtl/zstuff_pkg.sv
// Shared constants for the zero-stuffing transmitter.
package zstuff_pkg;
    // Default count of data ones after which a zero is inserted.
    localparam int unsigned RUN_LEN_DEF = 6;
    // Idle level of both output lines.
    localparam logic LINE_IDLE = 1'b1;
endpackage

// File: rtl/zstuff_run_ctrl.sv
// Run-of-ones tracker. Counts the data ones taken on strobe cycles and
// decides, strobe by strobe, whether the bit to emit is the data bit or an
// inserted zero.
// Assumes: bit_stb is a one-cycle strobe; the source holds ser_din across a
// strobe that emits an inserted zero; frame_start may land on any cycle.
module zstuff_run_ctrl #(
    parameter int unsigned RUN_LEN = zstuff_pkg::RUN_LEN_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic frame_start,
    input  logic ser_din,
    output logic stuff_now,
    output logic emit_bit
);
    localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] eff_cnt;

    // Select the bit to emit; frame_start makes the count look empty.
    always_comb begin
        eff_cnt   = frame_start ? '0 : run_cnt;
        stuff_now = bit_stb && (eff_cnt == CNT_MAX);
        emit_bit  = stuff_now ? 1'b0 : ser_din;
    end

    // Advance the ones count on strobes; clear on zero, insertion or frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (bit_stb) begin
            if (stuff_now || !ser_din) run_cnt <= '0;
            else                       run_cnt <= eff_cnt + 1'b1;
        end else if (frame_start) begin
            run_cnt <= '0;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CNT_MAX);                                                   // R1
    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !frame_start && run_cnt == CNT_MAX) |=> (run_cnt == '0));   // R3
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !bit_stb) |=> (run_cnt == '0));                         // R5
endmodule

// File: rtl/zstuff_line_enc.sv
// Output stage. Registers the emitted bit, the insertion flag and the
// transition-coded line level. All three change only on strobe cycles.
// Assumes: bit_in and stuff_in are valid when bit_stb is high.
module zstuff_line_enc (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic bit_in,
    input  logic stuff_in,
    output logic nrz_q,
    output logic nrzi_q,
    output logic flag_q
);
    // Capture the emitted bit and toggle the line on zeros, once per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nrz_q  <= zstuff_pkg::LINE_IDLE;
            nrzi_q <= zstuff_pkg::LINE_IDLE;
            flag_q <= 1'b0;
        end else if (bit_stb) begin
            nrz_q  <= bit_in;
            flag_q <= stuff_in;
            if (!bit_in) nrzi_q <= ~nrzi_q;
        end
    end

    AST_FLAG_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |-> !nrz_q);                                                     // R2
endmodule

// File: rtl/zstuff_nrzi_tx.sv
// Zero-stuffing NRZI transmitter top. Inserts a zero after every RUN_LEN
// data ones and line-codes the stuffed stream. It reports each inserted bit
// so the source can keep its pending bit for one more bit period.
// Assumes: one strobe per bit period; synchronous active-low reset.
module zstuff_nrzi_tx #(
    parameter int unsigned RUN_LEN = zstuff_pkg::RUN_LEN_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic ser_din,
    input  logic frame_start,
    output logic nrz_out,
    output logic nrzi_out,
    output logic stuff_flag
);
    logic stuff_now;
    logic emit_bit;

    zstuff_run_ctrl #(.RUN_LEN(RUN_LEN)) u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .frame_start (frame_start),
        .ser_din     (ser_din),
        .stuff_now   (stuff_now),
        .emit_bit    (emit_bit)
    );

    zstuff_line_enc u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .bit_in   (emit_bit),
        .stuff_in (stuff_now),
        .nrz_q    (nrz_out),
        .nrzi_q   (nrzi_out),
        .flag_q   (stuff_flag)
    );

    AST_NRZI_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> ((nrzi_out == $past(nrzi_out)) == nrz_out));                // R4
    AST_HOLD_OFF_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable({nrz_out, nrzi_out, stuff_flag}));                 // R6
endmodule

// File: tb/zstuff_nrzi_tx_tb.sv
module zstuff_nrzi_tx_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 38;
    // Each entry: {frame_start, ser_din, exp_nrz, exp_flag, exp_nrzi}
    localparam logic [4:0] VEC [NVEC] = '{
        5'b10000, 5'b00001,                                          // start, zeros toggle (R4,R5)
        5'b01101, 5'b01101, 5'b01101, 5'b01101, 5'b01101, 5'b01101,  // six ones
        5'b01010,                                                    // inserted zero, din=1 discarded (R1,R2)
        5'b01100,                                                    // held one taken (R2)
        5'b00001,
        5'b01101, 5'b01101, 5'b01101, 5'b01101, 5'b01101, 5'b01101,  // fresh run of six (R3)
        5'b00010,                                                    // insertion, din=0 discarded (R2)
        5'b00001,
        5'b01101, 5'b01101, 5'b01101, 5'b01101, 5'b01101,            // five ones
        5'b00000,                                                    // data zero: no insertion (R1)
        5'b01100, 5'b01100, 5'b01100, 5'b01100, 5'b01100,            // five ones
        5'b11100,                                                    // start with strobe: run restarts (R5)
        5'b01100, 5'b01100, 5'b01100, 5'b01100, 5'b01100,
        5'b01011,                                                    // insertion after fresh six (R1,R4)
        5'b01101
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0;
    logic ser_din = 1'b0;
    logic frame_start = 1'b0;
    logic nrz_out, nrzi_out, stuff_flag;
    int   n_chk = 0;
    int   n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zstuff_nrzi_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .ser_din(ser_din),
        .frame_start(frame_start), .nrz_out(nrz_out), .nrzi_out(nrzi_out),
        .stuff_flag(stuff_flag)
    );

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {nrz,flag,nrzi} got %b expected %b", req, got, exp);
        end
    endtask

    // One bit period: strobe in the first clock, then three idle clocks.
    // Outputs are compared one half clock after the strobe edge.
    task automatic send(input logic st, input logic d, input logic [2:0] exp, input string req);
        @(negedge clk);
        bit_stb = 1'b1; ser_din = d; frame_start = st;
        @(negedge clk);
        bit_stb = 1'b0; frame_start = 1'b0;
        check(req, {nrz_out, stuff_flag, nrzi_out}, exp);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset state", {nrz_out, stuff_flag, nrzi_out}, 3'b101);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++)
            send(VEC[i][4], VEC[i][3], VEC[i][2:0], "R1-table R8");

        // R6: off-strobe activity on din and frame_start changes nothing
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ser_din = k[0]; frame_start = ~k[0];
        end
        @(negedge clk);
        frame_start = 1'b0;
        check("R6 hold off strobe", {nrz_out, stuff_flag, nrzi_out}, 3'b101);

        // R5: start pulse on a non-strobe cycle clears a run of six
        for (int k = 0; k < 5; k++) send(1'b0, 1'b1, 3'b101, "R5 prep ones");
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        send(1'b0, 1'b1, 3'b101, "R5 no insertion after start");
        for (int k = 0; k < 5; k++) send(1'b0, 1'b1, 3'b101, "R5 run ones");
        send(1'b0, 1'b1, 3'b010, "R1 insertion after start run");

        // R7: mid-stream reset restores idle levels and clears the run
        for (int k = 0; k < 3; k++) send(1'b0, 1'b1, 3'b100, "R7 prep ones");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R7 mid-stream reset", {nrz_out, stuff_flag, nrzi_out}, 3'b101);
        for (int k = 0; k < 6; k++) send(1'b0, 1'b1, 3'b101, "R7 count cleared");
        send(1'b0, 1'b0, 3'b010, "R2 insertion flag after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule